// File: doc/BRIEF.md
# Eight-output addressable latch

This block holds a bank of independent storage bits (eight by default) that are written one at a time through a single data bit and a binary select. It is a synchronous, clocked model of a transparent addressable latch. While enable_n is low, the selected bit follows the data input on every rising clock edge. When enable_n returns high, the bit keeps the last value it took. Bits that are not selected keep their contents.

The active-low clear input sets the operating mode together with enable_n. With clear_n low and enable_n high, the whole bank is zeroed. With both low, the block acts as a one-hot demultiplexer: the selected bit carries the data and every other bit is forced to zero. A 2-bit mode code is driven combinationally from clear_n and enable_n so the surrounding logic can observe which mode is active. The select should only change while enable_n is high. A select change while enable_n is low simply writes whichever bit is selected at that edge.

Top module: `addr_latch_bank`

## Requirements
- R1: Select value s (binary, bit 0 of sel least significant) addresses output bit q[s]; for example sel=3'b101 addresses q[5] only.
- R2: With clear_n=1 and enable_n=0, q[sel] takes din at the next rising edge and every other bit of q keeps its value.
- R3: The value in the addressed bit at the last edge with enable_n low is retained after enable_n goes high, whatever din and sel do afterwards.
- R4: With clear_n=1 and enable_n=1, all bits of q keep their values at the next edge regardless of din and sel.
- R5: With clear_n=0 and enable_n=1, every bit of q is 0 after the next edge.
- R6: With clear_n=0 and enable_n=0, after the next edge q[sel] equals din and every other bit is 0.
- R7: With rst=1 at a rising edge, q is all zero after that edge, independent of clear_n, enable_n, din and sel.
- R8: mode_o follows clear_n and enable_n without a clock: 0 = latch (clear_n=1, enable_n=0), 1 = hold (1,1), 2 = demultiplex (0,0), 3 = clear (0,1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, zeroes q |
| din | input | 1 | Data bit to write into the addressed output |
| sel | input | SEL_W (3) | Binary index of the addressed output |
| enable_n | input | 1 | Active-low write enable |
| clear_n | input | 1 | Active-low bulk clear / demultiplex selector |
| q | output | NUM_OUTS (8) | Registered storage bits |
| mode_o | output | 2 | Current mode code |

## Verification
A walking write through all eight select values, each applied on top of a cleared bank, separates a correct select decode from swapped or shifted select bits. Preloading the bank with all ones before the demultiplex mode and the latch mode distinguishes "others are zeroed" from "others are kept". Changing din and sel right after enable_n rises checks that the captured bit is really frozen. Long random runs of din, sel, enable_n, clear_n and occasional rst are compared against a bit-level model, which covers mode transitions that the directed cases do not reach.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
   typedef enum logic [1:0] {
      MODE_LATCH = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_DEMUX = 2'd2,
      MODE_CLEAR = 2'd3
   } alatch_mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
   import alatch_pkg::*;
(
   input  logic         enable_n,
   input  logic         clear_n,
   output alatch_mode_e mode
);
   always_comb begin
      unique case ({clear_n, enable_n})
         2'b10:   mode = MODE_LATCH;
         2'b11:   mode = MODE_HOLD;
         2'b00:   mode = MODE_DEMUX;
         default: mode = MODE_CLEAR;
      endcase
   end
endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
   parameter int NUM_OUTS  = 8,
   parameter int SEL_W     = 3,
   parameter bit USE_SHIFT = 1'b0
) (
   input  logic [SEL_W-1:0]    sel,
   output logic [NUM_OUTS-1:0] hit
);
   generate
      if (USE_SHIFT) begin : g_shift
         assign hit = NUM_OUTS'(1) << sel;
      end else begin : g_cmp
         for (genvar i = 0; i < NUM_OUTS; i++) begin : g_bit
            assign hit[i] = (sel == SEL_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/alatch_cell.sv
module alatch_cell
   import alatch_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  logic         hit,
   input  logic         din,
   input  alatch_mode_e mode,
   output logic         q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else begin
         unique case (mode)
            MODE_LATCH: if (hit) q <= din;
            MODE_HOLD:  q <= q;
            MODE_DEMUX: q <= hit & din;
            default:    q <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
   import alatch_pkg::*;
#(
   parameter int  NUM_OUTS  = 8,
   parameter bit  USE_SHIFT = 1'b0,
   localparam int SEL_W     = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                din,
   input  logic [SEL_W-1:0]    sel,
   input  logic                enable_n,
   input  logic                clear_n,
   output logic [NUM_OUTS-1:0] q,
   output logic [1:0]          mode_o
);
   generate
      if (NUM_OUTS < 2) begin : g_bad_outs
         $error("addr_latch_bank: NUM_OUTS must be at least 2");
      end
      if ((1 << SEL_W) != NUM_OUTS) begin : g_bad_pow2
         $error("addr_latch_bank: NUM_OUTS must be a power of two");
      end
   endgenerate

   alatch_mode_e        mode;
   logic [NUM_OUTS-1:0] hit;

   alatch_mode_dec u_mode (
      .enable_n (enable_n),
      .clear_n  (clear_n),
      .mode     (mode)
   );

   alatch_sel_dec #(
      .NUM_OUTS  (NUM_OUTS),
      .SEL_W     (SEL_W),
      .USE_SHIFT (USE_SHIFT)
   ) u_sel (
      .sel (sel),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_cell
         alatch_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .hit  (hit[i]),
            .din  (din),
            .mode (mode),
            .q    (q[i])
         );
      end
   endgenerate

   assign mode_o = mode;
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
   parameter int NUM_OUTS = 8,
   parameter int SEL_W    = 3
) (
   input logic                clk,
   input logic                rst,
   input logic                din,
   input logic [SEL_W-1:0]    sel,
   input logic                enable_n,
   input logic                clear_n,
   input logic [NUM_OUTS-1:0] q,
   input logic [1:0]          mode_o
);
   logic [NUM_OUTS-1:0] mask;
   assign mask = NUM_OUTS'(1) << sel;

   // R7
   reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!clear_n && enable_n) |=> (q == '0));

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && enable_n) |=> $stable(q));

   // R2
   latch_others_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && !enable_n) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

   // R2
   latch_data_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && !enable_n) |=> (((q & $past(mask)) != '0) == $past(din)));

   // R6
   demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      (!clear_n && !enable_n) |=> ((q & ~$past(mask)) == '0) && ($countones(q) == int'($past(din))));

   // R8
   mode_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'd0) |-> (clear_n && !enable_n));

   // R8
   mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'd3) |-> (!clear_n && enable_n));
endmodule

bind addr_latch_bank addr_latch_bank_chk #(
   .NUM_OUTS (NUM_OUTS),
   .SEL_W    (SEL_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .din      (din),
   .sel      (sel),
   .enable_n (enable_n),
   .clear_n  (clear_n),
   .q        (q),
   .mode_o   (mode_o)
);

// File: tb/addr_latch_bank_test.sv
module addr_latch_bank_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       enable_n = 1'b1;
   logic       clear_n = 1'b1;
   logic [7:0] q;
   logic [1:0] mode_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] model = 8'h00;

   always #2.5 clk = ~clk;

   addr_latch_bank uut (
      .clk(clk), .rst(rst), .din(din), .sel(sel),
      .enable_n(enable_n), .clear_n(clear_n), .q(q), .mode_o(mode_o)
   );

   function automatic logic [1:0] exp_mode(logic cn, logic en);
      if (cn && !en) return 2'd0;
      if (cn && en)  return 2'd1;
      if (!cn && !en) return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [7:0] exp_next(logic [7:0] cur, logic r, logic d,
                                           logic [2:0] s, logic en, logic cn);
      logic [7:0] nxt;
      if (r) return 8'h00;
      nxt = cur;
      if (!cn) nxt = 8'h00;
      if (!en) nxt[s] = d;
      return nxt;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // drive at the falling edge, check mode, then check q just after the rising edge
   task automatic step(string req, logic r, logic d, logic [2:0] s, logic en, logic cn);
      @(negedge clk);
      rst = r; din = d; sel = s; enable_n = en; clear_n = cn;
      #1;
      if (!r) check("R8", {6'd0, mode_o}, {6'd0, exp_mode(cn, en)});
      model = exp_next(model, r, d, s, en, cn);
      @(posedge clk);
      #1;
      check(req, q, model);
   endtask

   initial begin
      #1_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240));
      // R7: reset state
      step("R7", 1'b1, 1'b1, 3'd3, 1'b0, 1'b0);
      step("R7", 1'b1, 1'b1, 3'd6, 1'b0, 1'b1);
      // R1: walking single writes over a cleared bank
      for (int s = 0; s < 8; s++) begin
         step("R5", 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
         step("R1", 1'b0, 1'b1, 3'(s), 1'b0, 1'b1);
      end
      step("R5", 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
      step("R1", 1'b0, 1'b1, 3'b101, 1'b0, 1'b1);
      check("R1", q, 8'h20);
      // R2: fill with ones, then write a zero into bit 3
      for (int s = 0; s < 8; s++) step("R2", 1'b0, 1'b1, 3'(s), 1'b0, 1'b1);
      check("R2", q, 8'hFF);
      step("R2", 1'b0, 1'b0, 3'd3, 1'b0, 1'b1);
      check("R2", q, 8'hF7);
      // R3: capture then disturb din/sel with enable_n high
      step("R3", 1'b0, 1'b1, 3'd3, 1'b0, 1'b1);
      step("R3", 1'b0, 1'b0, 3'd3, 1'b1, 1'b1);
      step("R3", 1'b0, 1'b0, 3'd0, 1'b1, 1'b1);
      check("R3", q, 8'hFF);
      // R4: hold under random din/sel
      for (int i = 0; i < 10; i++)
         step("R4", 1'b0, 1'($urandom), 3'($urandom), 1'b1, 1'b1);
      check("R4", q, 8'hFF);
      // R6: demux over a full bank
      step("R6", 1'b0, 1'b1, 3'd4, 1'b0, 1'b0);
      check("R6", q, 8'h10);
      step("R6", 1'b0, 1'b0, 3'd4, 1'b0, 1'b0);
      check("R6", q, 8'h00);
      step("R6", 1'b0, 1'b1, 3'd7, 1'b0, 1'b0);
      check("R6", q, 8'h80);
      // R5: clear
      step("R5", 1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
      check("R5", q, 8'h00);
      // R7: reset overrides a latch write
      step("R2", 1'b0, 1'b1, 3'd2, 1'b0, 1'b1);
      step("R7", 1'b1, 1'b1, 3'd2, 1'b0, 1'b1);
      check("R7", q, 8'h00);
      // random sequences: select changes mostly with enable_n high
      for (int i = 0; i < 3000; i++) begin
         logic en, cn, r;
         logic [2:0] s;
         en = ($urandom_range(0, 2) != 0);
         cn = ($urandom_range(0, 4) != 0);
         r  = ($urandom_range(0, 99) == 0);
         s  = en ? 3'($urandom) : sel;
         step(en ? (cn ? "R4" : "R5") : (cn ? "R2" : "R6"), r, 1'($urandom), s, en, cn);
      end
      finish_run();
   end
endmodule